// File: doc/BRIEF.md
# Codec Command Verb Decoder

This block sits behind the serial link front end of an audio codec and takes one 32-bit command word per frame. It compares the word's codec address with the address this codec was assigned. It then splits the word into a node ID and a verb. When the top nibble of the verb field marks a long verb, the verb is 12 bits wide and carries an 8-bit argument. Otherwise the verb is a 4-bit ID followed by a 16-bit payload.

The function-group node holds four small GPIO registers: output data, enable mask, direction, and unsolicited-event mask. It also answers parameter queries for a vendor identifier, a revision identifier and the GPIO capability word. Every accepted command produces one 32-bit response with a valid strobe on the next clock, ready for the next frame's response slot. That slot is wider (36 bits) than the command, and the front end adds the extra bits.

Top module: `cmd_verb_decoder`

## Requirements
- R1: After reset, rspValid is low and the four GPIO registers read back as zero.
- R2: A command whose bits 31:28 differ from myAddr produces no response and changes no register.
- R3: An accepted command (cmdValid high with a matching address) gives rspValid high for exactly one cycle, on the clock edge after the one that sampled the command. Commands on consecutive cycles each get their own response.
- R4: Node ID is bits 27:20. When bits 19:16 equal 7h or Fh, the verb is the 12-bit field 19:8 and its argument is bits 7:0. For any other value of bits 19:16, the verb is a 4-bit ID in 19:16 with a 16-bit payload in 15:0.
- R5: Verb F00h on node FG_NODE reads a parameter chosen by bits 7:0. Parameter 00h returns VENDOR_ID and parameter 02h returns REV_ID.
- R6: Parameter 11h returns the GPIO capability word. Bit 31 is 0 (no wake), bit 30 is 1 (unsolicited supported), bits 7:0 hold NUM_GPIO, and all other bits are 0.
- R7: On node FG_NODE, verbs 715h, 716h, 717h and 719h store argument bits 3:0 into the data, enable, direction and unsolicited registers in that order. They respond with all zeros.
- R8: Verbs F15h, F16h, F17h and F19h return the matching register in response bits 3:0, and bits 31:4 are zero.
- R9: Any other verb, any unknown parameter ID, and every short (4-bit) verb return an all-zero response with rspValid high, and leave the registers unchanged.
- R10: A set verb addressed to a node other than FG_NODE leaves the registers unchanged and returns all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| myAddr | input | 4 | Codec address assigned to this device |
| cmdValid | input | 1 | One-cycle strobe marking a new command word |
| cmdWord | input | 32 | Command word |
| rspValid | output | 1 | Response strobe, one cycle per accepted command |
| rspData | output | 32 | Response payload |

## Verification
Some properties are checked by assertions on every cycle:
- A response appears only after an accepted command, and never after an address mismatch.
- At most one register write strobe fires at a time.
- Registers hold their value when no write is strobed.
- The capability word keeps bit 31 clear and bit 30 set.
- GPIO reads keep their upper bits zero.

Other behaviour only the bench scenarios can show: that each register really takes the value written to it, the exact vendor and revision words, the order in which the four set verbs map to the four registers, and the precise one-cycle latency when commands arrive back to back.

// File: rtl/codec_cmd_pkg.sv
package codec_cmd_pkg;

  localparam logic [11:0] VERB_GET_PARAM = 12'hF00;
  localparam logic [11:0] VERB_SET_DATA  = 12'h715;
  localparam logic [11:0] VERB_SET_MASK  = 12'h716;
  localparam logic [11:0] VERB_SET_DIR   = 12'h717;
  localparam logic [11:0] VERB_SET_UNSOL = 12'h719;
  localparam logic [11:0] VERB_GET_DATA  = 12'hF15;
  localparam logic [11:0] VERB_GET_MASK  = 12'hF16;
  localparam logic [11:0] VERB_GET_DIR   = 12'hF17;
  localparam logic [11:0] VERB_GET_UNSOL = 12'hF19;

  localparam logic [7:0] PARM_VENDOR   = 8'h00;
  localparam logic [7:0] PARM_REVISION = 8'h02;
  localparam logic [7:0] PARM_GPIO_CAP = 8'h11;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_VENDOR,
    SEL_REV,
    SEL_CAPS,
    SEL_DATA,
    SEL_MASK,
    SEL_DIR,
    SEL_UNSOL
  } rspSel_e;

  typedef struct packed {
    logic    respond;
    logic    wrData;
    logic    wrMask;
    logic    wrDir;
    logic    wrUnsol;
    rspSel_e sel;
  } ctrlStrobe_t;

endpackage

// File: rtl/cmd_decode_ctrl.sv
module cmd_decode_ctrl
  import codec_cmd_pkg::*;
#(
  parameter logic [7:0] FG_NODE = 8'h01
) (
  input  logic        cmdValid,
  input  logic [31:0] cmdWord,
  input  logic [3:0]  myAddr,
  output ctrlStrobe_t strb
);

  logic        addrHit;
  logic        nodeHit;
  logic        isLong;
  logic [11:0] longVerb;
  logic [7:0]  argByte;
  logic        fgLong;

  assign addrHit  = (cmdWord[31:28] == myAddr);
  assign nodeHit  = (cmdWord[27:20] == FG_NODE);
  assign isLong   = (cmdWord[19:16] == 4'h7) || (cmdWord[19:16] == 4'hF);
  assign longVerb = cmdWord[19:8];
  assign argByte  = cmdWord[7:0];
  assign fgLong   = cmdValid && addrHit && nodeHit && isLong;

  always_comb begin
    strb         = '0;
    strb.sel     = SEL_ZERO;
    strb.respond = cmdValid && addrHit;
    if (fgLong) begin
      unique case (longVerb)
        VERB_SET_DATA:  strb.wrData  = 1'b1;
        VERB_SET_MASK:  strb.wrMask  = 1'b1;
        VERB_SET_DIR:   strb.wrDir   = 1'b1;
        VERB_SET_UNSOL: strb.wrUnsol = 1'b1;
        VERB_GET_DATA:  strb.sel     = SEL_DATA;
        VERB_GET_MASK:  strb.sel     = SEL_MASK;
        VERB_GET_DIR:   strb.sel     = SEL_DIR;
        VERB_GET_UNSOL: strb.sel     = SEL_UNSOL;
        VERB_GET_PARAM: begin
          unique case (argByte)
            PARM_VENDOR:   strb.sel = SEL_VENDOR;
            PARM_REVISION: strb.sel = SEL_REV;
            PARM_GPIO_CAP: strb.sel = SEL_CAPS;
            default:       strb.sel = SEL_ZERO;
          endcase
        end
        default: strb.sel = SEL_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/cmd_gpio_regs.sv
module cmd_gpio_regs
  import codec_cmd_pkg::*;
#(
  parameter int          NUM_GPIO  = 4,
  parameter logic [31:0] VENDOR_ID = 32'h1D5A_0262,
  parameter logic [31:0] REV_ID    = 32'h0010_0400
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic [NUM_GPIO-1:0] wrVal,
  output logic                rspValid,
  output logic [31:0]         rspData
);

  localparam int PAD = 32 - NUM_GPIO;
  localparam logic [31:0] CAPS_WORD = {1'b0, 1'b1, 22'd0, 8'(NUM_GPIO)};

  logic [NUM_GPIO-1:0] regData, regMask, regDir, regUnsol;
  logic [31:0]         rspNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regData  <= '0;
      regMask  <= '0;
      regDir   <= '0;
      regUnsol <= '0;
    end else begin
      if (strb.wrData)  regData  <= wrVal;
      if (strb.wrMask)  regMask  <= wrVal;
      if (strb.wrDir)   regDir   <= wrVal;
      if (strb.wrUnsol) regUnsol <= wrVal;
    end
  end

  always_comb begin
    unique case (strb.sel)
      SEL_VENDOR: rspNext = VENDOR_ID;
      SEL_REV:    rspNext = REV_ID;
      SEL_CAPS:   rspNext = CAPS_WORD;
      SEL_DATA:   rspNext = {{PAD{1'b0}}, regData};
      SEL_MASK:   rspNext = {{PAD{1'b0}}, regMask};
      SEL_DIR:    rspNext = {{PAD{1'b0}}, regDir};
      SEL_UNSOL:  rspNext = {{PAD{1'b0}}, regUnsol};
      default:    rspNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.respond;
      rspData  <= strb.respond ? rspNext : '0;
    end
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrData, strb.wrMask, strb.wrDir, strb.wrUnsol})); // R7

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrData || strb.wrMask || strb.wrDir || strb.wrUnsol)
      |=> $stable({regData, regMask, regDir, regUnsol})); // R9

  AST_CAPS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.respond && strb.sel == SEL_CAPS) |=> (rspData[31:30] == 2'b01)); // R6

  AST_GET_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.respond && strb.sel >= SEL_DATA) |=> (rspData[31:NUM_GPIO] == '0)); // R8

endmodule

// File: rtl/cmd_verb_decoder.sv
module cmd_verb_decoder
  import codec_cmd_pkg::*;
#(
  parameter logic [7:0]  FG_NODE   = 8'h01,
  parameter int          NUM_GPIO  = 4,
  parameter logic [31:0] VENDOR_ID = 32'h1D5A_0262,
  parameter logic [31:0] REV_ID    = 32'h0010_0400
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  myAddr,
  input  logic        cmdValid,
  input  logic [31:0] cmdWord,
  output logic        rspValid,
  output logic [31:0] rspData
);

  ctrlStrobe_t strb;

  cmd_decode_ctrl #(.FG_NODE(FG_NODE)) uCtrl (
    .cmdValid (cmdValid),
    .cmdWord  (cmdWord),
    .myAddr   (myAddr),
    .strb     (strb)
  );

  cmd_gpio_regs #(
    .NUM_GPIO  (NUM_GPIO),
    .VENDOR_ID (VENDOR_ID),
    .REV_ID    (REV_ID)
  ) uRegs (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrVal    (cmdWord[NUM_GPIO-1:0]),
    .rspValid (rspValid),
    .rspData  (rspData)
  );

  AST_RSP_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(cmdValid && (cmdWord[31:28] == myAddr))); // R3

  AST_NO_RSP_MISMATCH: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdWord[31:28] != myAddr)) |=> !rspValid); // R2

endmodule

// File: tb/sim_cmd_verb_decoder.sv
module sim_cmd_verb_decoder;

  localparam logic [31:0] VEND = 32'hBEEF_1234;
  localparam logic [31:0] REVW = 32'h0031_0702;
  localparam logic [3:0]  ADDR = 4'h2;
  localparam logic [7:0]  FGN  = 8'h01;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [31:0] cmdWord = '0;
  logic        rspValid;
  logic [31:0] rspData;

  always #5 clk = ~clk;

  cmd_verb_decoder #(
    .FG_NODE(FGN), .NUM_GPIO(4), .VENDOR_ID(VEND), .REV_ID(REVW)
  ) u0 (
    .clk(clk), .rstN(rstN), .myAddr(ADDR), .cmdValid(cmdValid),
    .cmdWord(cmdWord), .rspValid(rspValid), .rspData(rspData)
  );

  typedef struct {
    logic [31:0] data;
    int          due;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int vectors = 0;
  int fails   = 0;
  int cycle   = 0;
  int rspSeen = 0;
  bit done    = 0;

  always @(posedge clk) cycle <= cycle + 1;

  function automatic logic [31:0] lng(logic [3:0] a, logic [7:0] n,
                                      logic [11:0] v, logic [7:0] d);
    return {a, n, v, d};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // driver: called at a negedge, holds the command for one edge
  task automatic send(logic [31:0] w, bit expect_rsp, logic [31:0] exp, string tag);
    cmdValid = 1'b1;
    cmdWord  = w;
    if (expect_rsp) expQ.push_back('{exp, cycle + 1, tag});
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      rspSeen++;
      if (expQ.size() == 0) begin
        check(1'b0, "R3 unexpected response", rspData, 32'h0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(rspData == it.data, it.tag, rspData, it.data);
        check(cycle == it.due, {it.tag, " R3 latency"}, 32'(cycle), 32'(it.due));
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    int snap;
    idle(3);
    check(rspValid == 1'b0, "R1 rspValid in reset", 32'(rspValid), 32'h0);
    rstN = 1'b1;
    idle(1);
    check(rspValid == 1'b0, "R1 rspValid after reset", 32'(rspValid), 32'h0);

    // R1 / R8: registers start at zero
    send(lng(ADDR, FGN, 12'hF15, 8'h00), 1, 32'h0, "R1 data reset");
    send(lng(ADDR, FGN, 12'hF16, 8'h00), 1, 32'h0, "R1 mask reset");
    send(lng(ADDR, FGN, 12'hF17, 8'h00), 1, 32'h0, "R1 dir reset");
    send(lng(ADDR, FGN, 12'hF19, 8'h00), 1, 32'h0, "R1 unsol reset");
    idle(2);

    // R5 / R6 / R9: parameters
    send(lng(ADDR, FGN, 12'hF00, 8'h00), 1, VEND, "R5 vendor");
    idle(1);
    send(lng(ADDR, FGN, 12'hF00, 8'h02), 1, REVW, "R5 revision");
    send(lng(ADDR, FGN, 12'hF00, 8'h11), 1, 32'h4000_0004, "R6 gpio caps");
    send(lng(ADDR, FGN, 12'hF00, 8'h05), 1, 32'h0, "R9 unknown param");
    idle(2);

    // R7: writes, upper argument bits dropped
    send(lng(ADDR, FGN, 12'h715, 8'hA5), 1, 32'h0, "R7 set data");
    send(lng(ADDR, FGN, 12'h716, 8'h3C), 1, 32'h0, "R7 set mask");
    idle(1);
    send(lng(ADDR, FGN, 12'h717, 8'h0F), 1, 32'h0, "R7 set dir");
    send(lng(ADDR, FGN, 12'h719, 8'hF9), 1, 32'h0, "R7 set unsol");

    // R8: read back, back to back (R3)
    send(lng(ADDR, FGN, 12'hF15, 8'h00), 1, 32'h5, "R8 get data");
    send(lng(ADDR, FGN, 12'hF16, 8'h00), 1, 32'hC, "R8 get mask");
    send(lng(ADDR, FGN, 12'hF17, 8'h00), 1, 32'hF, "R8 get dir");
    send(lng(ADDR, FGN, 12'hF19, 8'h00), 1, 32'h9, "R8 get unsol");
    idle(2);

    // R4 / R9: short verb whose payload resembles a set; unknown long verb
    send({ADDR, FGN, 4'h3, 16'h1500}, 1, 32'h0, "R4 short verb");
    send({ADDR, FGN, 4'h2, 16'h7150}, 1, 32'h0, "R4 short verb 2");
    send(lng(ADDR, FGN, 12'h70A, 8'h33), 1, 32'h0, "R9 unknown verb");
    send(lng(ADDR, FGN, 12'hF15, 8'h00), 1, 32'h5, "R9 data unchanged");

    // R2: address mismatch
    idle(2);
    snap = rspSeen;
    send(lng(4'h7, FGN, 12'h715, 8'h02), 0, 32'h0, "R2");
    idle(3);
    check(rspSeen == snap, "R2 no response on mismatch", 32'(rspSeen - snap), 32'h0);
    send(lng(ADDR, FGN, 12'hF15, 8'h00), 1, 32'h5, "R2 data unchanged");

    // R10: other node
    send(lng(ADDR, 8'h14, 12'h716, 8'h01), 1, 32'h0, "R10 other node set");
    send(lng(ADDR, FGN, 12'hF16, 8'h00), 1, 32'hC, "R10 mask unchanged");
    send(lng(ADDR, 8'h14, 12'hF00, 8'h00), 1, 32'h0, "R10 other node param");

    // R7 rewrite to zero
    send(lng(ADDR, FGN, 12'h717, 8'hF0), 1, 32'h0, "R7 set dir zero");
    send(lng(ADDR, FGN, 12'hF17, 8'h00), 1, 32'h0, "R8 get dir zero");
    idle(4);
    check(expQ.size() == 0, "R3 all responses delivered", 32'(expQ.size()), 32'h0);
    finishRun();
  end

endmodule